// File: doc/BRIEF.md
# Translation cache with selective flush

This block is a small, fully associative cache of address translations. Each of its entries is tagged by a function code and a logical page number. It stores a physical page number plus a write-protect flag and a modified flag. Lookups are combinational: a request presented in a cycle gets hit or miss, together with the stored physical page and flags, in that same cycle.

A single command port carries the maintenance operations. Each one completes in one clock. The operations are: drop every entry; drop all entries carrying one function code; drop the single entry for one code and page; install a translation handed over by an external table walker; and probe. Before it writes, an install removes any entry that already maps the same code and page, so no address is ever mapped twice. A probe records the outcome of a search in a small status register and changes nothing else. Installs and flushes never touch that register.

When an install finds no free slot, a round-robin pointer names the victim. Reset is asynchronous and active low, and is released through a two-stage synchronizer.

Top module: `tcache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses. The status outputs stat_hit, stat_wp, stat_mod and stat_slot all read zero, and the round-robin pointer is at slot 0.
- R2: In the same cycle, a lookup with lk_valid=1 and no command hits when some valid entry has an equal function code and an equal logical page. In that case lk_ppn, lk_wp and lk_mod carry that entry's stored values.
- R3: A lookup misses when no valid entry matches, including the case where only the function code or only the page differs. On a miss, lk_ppn, lk_wp and lk_mod are zero.
- R4: cmd_op=0 (flush all) invalidates every entry. The effect is visible from the cycle after the command.
- R5: cmd_op=1 (flush by code) invalidates every entry whose function code equals cmd_fc, whatever its page. Entries carrying other codes stay.
- R6: cmd_op=2 (flush one page) invalidates only the entry that matches both cmd_fc and cmd_lpn.
- R7: cmd_op=3 (install) first invalidates any entry that matches cmd_fc and cmd_lpn, then writes cmd_ppn, cmd_wp and cmd_mod under that tag. At most one valid entry ever matches a given code and page.
- R8: An install goes to the lowest-numbered slot that is free, counting a slot freed by the purge as free. If no slot is free, it goes to the slot named by the round-robin pointer. The pointer steps by one, wrapping, on every install and on nothing else.
- R9: cmd_op=4 (probe) loads the status outputs at the next clock edge: stat_hit, plus stat_wp, stat_mod and stat_slot of the matching entry, or zeros on a miss. A probe never changes any entry or the pointer.
- R10: Installs and flushes leave stat_hit, stat_wp, stat_mod and stat_slot unchanged.
- R11: While cmd_valid=1, a lookup in the same cycle is reported as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_fc | input | 3 | Lookup function code |
| lk_lpn | input | 20 | Lookup logical page |
| lk_hit | output | 1 | Lookup hit, same cycle |
| lk_ppn | output | 20 | Physical page on hit |
| lk_wp | output | 1 | Write-protect flag on hit |
| lk_mod | output | 1 | Modified flag on hit |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 0 flush all, 1 flush code, 2 flush page, 3 install, 4 probe |
| cmd_fc | input | 3 | Command function code |
| cmd_lpn | input | 20 | Command logical page |
| cmd_ppn | input | 20 | Physical page to install |
| cmd_wp | input | 1 | Write-protect flag to install |
| cmd_mod | input | 1 | Modified flag to install |
| stat_hit | output | 1 | Probe result: hit |
| stat_wp | output | 1 | Probe result: write-protect flag |
| stat_mod | output | 1 | Probe result: modified flag |
| stat_slot | output | 3 | Probe result: slot index |

## Verification
Lookup outputs are combinational, so the bench drives a lookup just after a falling edge and compares lk_hit and the payload 1 ns later, in the same cycle. Commands take effect at the following rising edge, and the same holds for the probe status register. The bench therefore checks their effects, with a lookup or a probe, only from the next falling edge onward. After rst_n is released, the two-stage synchronizer holds the block in reset for two more rising edges, and the bench waits three edges before it drives anything. Victim choice is observed through stat_slot, using probes issued after each install.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [2:0] {
    OP_FLUSH_ALL  = 3'd0,
    OP_FLUSH_FC   = 3'd1,
    OP_FLUSH_PAGE = 3'd2,
    OP_PRELOAD    = 3'd3,
    OP_PROBE      = 3'd4
  } tc_op_e;
endpackage

// File: rtl/tc_match.sv
// Parallel tag compare across all entries
module tc_match #(
  parameter int N   = 8,
  parameter int FCW = 3,
  parameter int PW  = 20
) (
  input  logic [N-1:0]          vld,
  input  logic [N-1:0][FCW-1:0] fc_tag,
  input  logic [N-1:0][PW-1:0]  pg_tag,
  input  logic [FCW-1:0]        key_fc,
  input  logic [PW-1:0]         key_pg,
  input  logic                  use_page,
  output logic [N-1:0]          hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = vld[g] && (fc_tag[g] == key_fc) &&
                    (!use_page || (pg_tag[g] == key_pg));
  end
endmodule

// File: rtl/tc_sel.sv
// One-hot payload multiplexer
module tc_sel #(
  parameter int N  = 8,
  parameter int PW = 20
) (
  input  logic [N-1:0]         sel,
  input  logic [N-1:0][PW-1:0] ppn_in,
  input  logic [N-1:0]         wp_in,
  input  logic [N-1:0]         md_in,
  output logic [PW-1:0]        ppn,
  output logic                 wp,
  output logic                 md
);
  always_comb begin
    ppn = '0;
    wp  = 1'b0;
    md  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) begin
        ppn = ppn | ppn_in[i];
        wp  = wp | wp_in[i];
        md  = md | md_in[i];
      end
    end
  end
endmodule

// File: rtl/tc_victim.sv
// Insert slot choice: lowest free slot, else round-robin pointer
module tc_victim #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vld,
  input  logic [N-1:0]  purge,
  input  logic          adv,
  output logic [IW-1:0] slot,
  output logic [IW-1:0] ptr
);
  logic [N-1:0]  free_v;
  logic [IW-1:0] low_free;
  logic          any_free;
  logic [IW-1:0] ptr_d;

  assign free_v   = ~vld | purge;
  assign any_free = |free_v;

  always_comb begin
    low_free = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_v[i]) low_free = IW'(i);
    end
  end

  assign slot = any_free ? low_free : ptr;

  always_comb begin
    ptr_d = ptr;
    if (adv) begin
      if (ptr == IW'(N - 1)) ptr_d = '0;
      else                   ptr_d = ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= ptr_d;
  end
endmodule

// File: rtl/tc_status.sv
// Probe result register
module tc_status #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          hit_in,
  input  logic          wp_in,
  input  logic          md_in,
  input  logic [IW-1:0] slot_in,
  output logic          hit,
  output logic          wp,
  output logic          md,
  output logic [IW-1:0] slot
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit  <= 1'b0;
      wp   <= 1'b0;
      md   <= 1'b0;
      slot <= '0;
    end else if (load) begin
      hit  <= hit_in;
      wp   <= wp_in;
      md   <= md_in;
      slot <= slot_in;
    end
  end
endmodule

// File: rtl/tcache.sv
module tcache #(
  parameter int ENTRIES = 8,
  parameter int FC_W    = 3,
  parameter int PAGE_W  = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [FC_W-1:0]   lk_fc,
  input  logic [PAGE_W-1:0] lk_lpn,
  output logic              lk_hit,
  output logic [PAGE_W-1:0] lk_ppn,
  output logic              lk_wp,
  output logic              lk_mod,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [FC_W-1:0]   cmd_fc,
  input  logic [PAGE_W-1:0] cmd_lpn,
  input  logic [PAGE_W-1:0] cmd_ppn,
  input  logic              cmd_wp,
  input  logic              cmd_mod,
  output logic              stat_hit,
  output logic              stat_wp,
  output logic              stat_mod,
  output logic [IDX_W-1:0]  stat_slot
);
  import tc_pkg::*;

  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  // entry storage
  logic [ENTRIES-1:0]             v_q, v_d;
  logic [ENTRIES-1:0][FC_W-1:0]   fc_q;
  logic [ENTRIES-1:0][PAGE_W-1:0] lpn_q, ppn_q;
  logic [ENTRIES-1:0]             wp_q, md_q;
  logic [ENTRIES-1:0]             we;

  // command decode
  logic do_preload, do_probe, cmd_use_page;
  assign do_preload   = cmd_valid && (cmd_op == OP_PRELOAD);
  assign do_probe     = cmd_valid && (cmd_op == OP_PROBE);
  assign cmd_use_page = (cmd_op != OP_FLUSH_FC);

  // lookup path
  logic [ENTRIES-1:0] lk_raw, lk_sel;

  tc_match #(.N(ENTRIES), .FCW(FC_W), .PW(PAGE_W)) u_lk_match (
    .vld(v_q), .fc_tag(fc_q), .pg_tag(lpn_q),
    .key_fc(lk_fc), .key_pg(lk_lpn), .use_page(1'b1), .hit(lk_raw)
  );

  assign lk_sel = lk_raw & {ENTRIES{lk_valid & ~cmd_valid}};
  assign lk_hit = |lk_sel;

  tc_sel #(.N(ENTRIES), .PW(PAGE_W)) u_lk_sel (
    .sel(lk_sel), .ppn_in(ppn_q), .wp_in(wp_q), .md_in(md_q),
    .ppn(lk_ppn), .wp(lk_wp), .md(lk_mod)
  );

  // command path
  logic [ENTRIES-1:0] cmd_sel;

  tc_match #(.N(ENTRIES), .FCW(FC_W), .PW(PAGE_W)) u_cmd_match (
    .vld(v_q), .fc_tag(fc_q), .pg_tag(lpn_q),
    .key_fc(cmd_fc), .key_pg(cmd_lpn), .use_page(cmd_use_page), .hit(cmd_sel)
  );

  logic [PAGE_W-1:0] pr_ppn;
  logic              pr_wp, pr_md;
  logic [IDX_W-1:0]  pr_slot;

  tc_sel #(.N(ENTRIES), .PW(PAGE_W)) u_cmd_sel (
    .sel(cmd_sel), .ppn_in(ppn_q), .wp_in(wp_q), .md_in(md_q),
    .ppn(pr_ppn), .wp(pr_wp), .md(pr_md)
  );

  always_comb begin
    pr_slot = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (cmd_sel[i]) pr_slot = pr_slot | IDX_W'(i);
    end
  end

  logic [IDX_W-1:0] ins_slot, rr_ptr;

  tc_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_sync_n), .vld(v_q), .purge(cmd_sel),
    .adv(do_preload), .slot(ins_slot), .ptr(rr_ptr)
  );

  tc_status #(.IW(IDX_W)) u_status (
    .clk(clk), .rst_n(rst_sync_n), .load(do_probe),
    .hit_in(|cmd_sel), .wp_in(pr_wp), .md_in(pr_md), .slot_in(pr_slot),
    .hit(stat_hit), .wp(stat_wp), .md(stat_mod), .slot(stat_slot)
  );

  // next-state for valid bits and write enables
  always_comb begin
    v_d = v_q;
    we  = '0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_FLUSH_ALL:  v_d = '0;
        OP_FLUSH_FC,
        OP_FLUSH_PAGE: v_d = v_q & ~cmd_sel;
        OP_PRELOAD: begin
          v_d           = v_q & ~cmd_sel;
          v_d[ins_slot] = 1'b1;
          we[ins_slot]  = 1'b1;
        end
        default: v_d = v_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) v_q <= '0;
    else             v_q <= v_d;
  end

  // payload registers carry no reset; valid bits gate every use
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (we[g]) begin
        fc_q[g]  <= cmd_fc;
        lpn_q[g] <= cmd_lpn;
        ppn_q[g] <= cmd_ppn;
        wp_q[g]  <= cmd_wp;
        md_q[g]  <= cmd_mod;
      end
    end
  end

  logic unused_pr;
  assign unused_pr = ^pr_ppn;
endmodule

// File: rtl/tcache_chk.sv
module tcache_chk #(
  parameter int N   = 8,
  parameter int FCW = 3,
  parameter int IW  = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic [2:0]          cmd_op,
  input logic [FCW-1:0]      cmd_fc,
  input logic                lk_hit,
  input logic                stat_hit,
  input logic                stat_wp,
  input logic                stat_mod,
  input logic [IW-1:0]       stat_slot,
  input logic [N-1:0]        vld,
  input logic [N-1:0][FCW-1:0] fc_tag,
  input logic [IW-1:0]       rr_ptr,
  input logic [N-1:0]        lk_vec
);
  logic [FCW-1:0] fc_prev;
  logic           fc_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fc_prev <= '0;
    else        fc_prev <= cmd_fc;
  end

  always_comb begin
    fc_left = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (vld[i] && (fc_tag[i] == fc_prev)) fc_left = 1'b1;
    end
  end

  AST_FLUSH_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd0) |=> (vld == '0)); // R4

  AST_FLUSH_FC_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1) |=> !fc_left); // R5

  AST_SINGLE_MAPPING: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec)); // R7

  AST_PTR_ONLY_ON_INSTALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_op == 3'd3) |=> $stable(rr_ptr)); // R8

  AST_PROBE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd4) |=> ($stable(vld) && $stable(rr_ptr))); // R9

  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != 3'd4) |=>
      $stable({stat_hit, stat_wp, stat_mod, stat_slot})); // R10

  AST_CMD_MASKS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !lk_hit); // R11
endmodule

bind tcache tcache_chk #(.N(ENTRIES), .FCW(FC_W), .IW(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_fc(cmd_fc), .lk_hit(lk_hit), .stat_hit(stat_hit), .stat_wp(stat_wp),
  .stat_mod(stat_mod), .stat_slot(stat_slot), .vld(v_q), .fc_tag(fc_q),
  .rr_ptr(rr_ptr), .lk_vec(lk_raw)
);

// File: tb/tcache_test.sv
module tcache_test;
  logic        clk;
  logic        rst_n;
  logic        lk_valid;
  logic [2:0]  lk_fc;
  logic [19:0] lk_lpn;
  logic        lk_hit;
  logic [19:0] lk_ppn;
  logic        lk_wp, lk_mod;
  logic        cmd_valid;
  logic [2:0]  cmd_op, cmd_fc;
  logic [19:0] cmd_lpn, cmd_ppn;
  logic        cmd_wp, cmd_mod;
  logic        stat_hit, stat_wp, stat_mod;
  logic [2:0]  stat_slot;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  tcache uut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        is_cmd;
    logic [2:0]  op;
    logic [2:0]  fc;
    logic [19:0] lpn;
    logic [19:0] ppn;
    logic        wp;
    logic        md;
    logic        exp_hit;
    logic [19:0] exp_ppn;
    logic        exp_wp;
    logic        exp_md;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd3, 3'd1, 20'h00010, 20'hAAAAA, 1'b0, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 4'd7},
    '{1'b1, 3'd3, 3'd2, 20'h00010, 20'hBBBBB, 1'b0, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0, 4'd7},
    '{1'b1, 3'd3, 3'd1, 20'h00020, 20'hCCCCC, 1'b1, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 4'd7},
    '{1'b1, 3'd3, 3'd4, 20'h00010, 20'h44444, 1'b0, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 4'd7},
    '{1'b0, 3'd0, 3'd1, 20'h00010, 20'h0, 1'b0, 1'b0, 1'b1, 20'hAAAAA, 1'b0, 1'b0, 4'd2}, // R2
    '{1'b0, 3'd0, 3'd2, 20'h00010, 20'h0, 1'b0, 1'b0, 1'b1, 20'hBBBBB, 1'b0, 1'b1, 4'd2}, // R2
    '{1'b0, 3'd0, 3'd1, 20'h00020, 20'h0, 1'b0, 1'b0, 1'b1, 20'hCCCCC, 1'b1, 1'b0, 4'd2}, // R2
    '{1'b0, 3'd0, 3'd3, 20'h00010, 20'h0, 1'b0, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 4'd3},     // R3 code differs
    '{1'b0, 3'd0, 3'd1, 20'h00011, 20'h0, 1'b0, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 4'd3},     // R3 page differs
    '{1'b1, 3'd3, 3'd1, 20'h00010, 20'hDDDDD, 1'b0, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0, 4'd7}, // R7 duplicate
    '{1'b0, 3'd0, 3'd1, 20'h00010, 20'h0, 1'b0, 1'b0, 1'b1, 20'hDDDDD, 1'b0, 1'b1, 4'd7}, // R7
    '{1'b1, 3'd2, 3'd2, 20'h00010, 20'h0, 1'b0, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 4'd6},     // R6
    '{1'b0, 3'd0, 3'd2, 20'h00010, 20'h0, 1'b0, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 4'd6},     // R6
    '{1'b0, 3'd0, 3'd1, 20'h00010, 20'h0, 1'b0, 1'b0, 1'b1, 20'hDDDDD, 1'b0, 1'b1, 4'd6}, // R6
    '{1'b1, 3'd1, 3'd1, 20'h00000, 20'h0, 1'b0, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 4'd5},     // R5
    '{1'b0, 3'd0, 3'd1, 20'h00010, 20'h0, 1'b0, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 4'd5},     // R5
    '{1'b0, 3'd0, 3'd1, 20'h00020, 20'h0, 1'b0, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 4'd5},     // R5
    '{1'b0, 3'd0, 3'd4, 20'h00010, 20'h0, 1'b0, 1'b0, 1'b1, 20'h44444, 1'b0, 1'b0, 4'd5}, // R5
    '{1'b1, 3'd0, 3'd0, 20'h00000, 20'h0, 1'b0, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 4'd4},     // R4
    '{1'b0, 3'd0, 3'd4, 20'h00010, 20'h0, 1'b0, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 4'd4}      // R4
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // starts and ends just after a falling edge
  task automatic cmd(input logic [2:0] op, input logic [2:0] fc, input logic [19:0] lpn,
                     input logic [19:0] ppn, input logic wp, input logic md);
    cmd_valid = 1'b1; cmd_op = op; cmd_fc = fc; cmd_lpn = lpn;
    cmd_ppn = ppn; cmd_wp = wp; cmd_mod = md;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic look(input logic [2:0] fc, input logic [19:0] lpn, input logic eh,
                      input logic [19:0] ep, input logic ew, input logic em, input string req);
    lk_valid = 1'b1; lk_fc = fc; lk_lpn = lpn;
    #1;
    chk(lk_hit == eh, req, "lk_hit", 32'(lk_hit), 32'(eh));
    if (eh) begin
      chk(lk_ppn == ep, req, "lk_ppn", 32'(lk_ppn), 32'(ep));
      chk(lk_wp == ew,  req, "lk_wp",  32'(lk_wp),  32'(ew));
      chk(lk_mod == em, req, "lk_mod", 32'(lk_mod), 32'(em));
    end else begin
      chk(lk_ppn == '0, req, "lk_ppn on miss", 32'(lk_ppn), 32'h0);
    end
    lk_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic stat_is(input logic h, input logic w, input logic m,
                         input logic [2:0] s, input string req);
    chk(stat_hit == h,  req, "stat_hit",  32'(stat_hit),  32'(h));
    chk(stat_wp == w,   req, "stat_wp",   32'(stat_wp),   32'(w));
    chk(stat_mod == m,  req, "stat_mod",  32'(stat_mod),  32'(m));
    chk(stat_slot == s, req, "stat_slot", 32'(stat_slot), 32'(s));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    lk_valid = 1'b0; lk_fc = '0; lk_lpn = '0;
    cmd_valid = 1'b0; cmd_op = '0; cmd_fc = '0; cmd_lpn = '0;
    cmd_ppn = '0; cmd_wp = 1'b0; cmd_mod = 1'b0;
    do_reset();

    // R1: reset state
    stat_is(1'b0, 1'b0, 1'b0, 3'd0, "R1");
    look(3'd0, 20'h00000, 1'b0, 20'h0, 1'b0, 1'b0, "R1");

    // vector table
    for (int k = 0; k < NV; k++) begin
      if (VECS[k].is_cmd)
        cmd(VECS[k].op, VECS[k].fc, VECS[k].lpn, VECS[k].ppn, VECS[k].wp, VECS[k].md);
      else
        look(VECS[k].fc, VECS[k].lpn, VECS[k].exp_hit, VECS[k].exp_ppn,
             VECS[k].exp_wp, VECS[k].exp_md, $sformatf("R%0d", VECS[k].req));
    end

    // R8: fill from a clean reset, pointer at 0
    do_reset();
    for (int i = 0; i < 8; i++) begin
      cmd(3'd3, 3'd0, 20'h00100 + 20'(i), 20'h50000 + 20'(i), i[0], i[1]);
      cmd(3'd4, 3'd0, 20'h00100 + 20'(i), 20'h0, 1'b0, 1'b0);
      stat_is(1'b1, i[0], i[1], 3'(i), "R8");
    end
    look(3'd0, 20'h00103, 1'b1, 20'h50003, 1'b1, 1'b1, "R2");

    // R9: probe miss reports zeros, probes leave contents alone
    cmd(3'd4, 3'd0, 20'h00999, 20'h0, 1'b0, 1'b0);
    stat_is(1'b0, 1'b0, 1'b0, 3'd0, "R9");
    cmd(3'd4, 3'd0, 20'h00103, 20'h0, 1'b0, 1'b0);
    stat_is(1'b1, 1'b1, 1'b1, 3'd3, "R9");

    // R11: command in flight masks a hitting lookup
    cmd_valid = 1'b1; cmd_op = 3'd4; cmd_fc = 3'd0; cmd_lpn = 20'h00103;
    lk_valid = 1'b1; lk_fc = 3'd0; lk_lpn = 20'h00101;
    #1;
    chk(lk_hit == 1'b0, "R11", "lk_hit with command", 32'(lk_hit), 32'h0);
    lk_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;

    // full cache: install evicts pointer slot 0; status held (R10)
    cmd(3'd3, 3'd0, 20'h00200, 20'h60000, 1'b0, 1'b0);
    stat_is(1'b1, 1'b1, 1'b1, 3'd3, "R10");
    look(3'd0, 20'h00100, 1'b0, 20'h0, 1'b0, 1'b0, "R8");
    look(3'd0, 20'h00200, 1'b1, 20'h60000, 1'b0, 1'b0, "R8");
    cmd(3'd2, 3'd0, 20'h00107, 20'h0, 1'b0, 1'b0);
    stat_is(1'b1, 1'b1, 1'b1, 3'd3, "R10");
    look(3'd0, 20'h00107, 1'b0, 20'h0, 1'b0, 1'b0, "R6");

    // freed slot 7 is preferred over the pointer
    cmd(3'd3, 3'd0, 20'h00201, 20'h60001, 1'b0, 1'b0);
    cmd(3'd4, 3'd0, 20'h00201, 20'h0, 1'b0, 1'b0);
    stat_is(1'b1, 1'b0, 1'b0, 3'd7, "R8");
    // full again: pointer now at 2 (stepped on each install only)
    cmd(3'd3, 3'd0, 20'h00202, 20'h60002, 1'b1, 1'b0);
    cmd(3'd4, 3'd0, 20'h00202, 20'h0, 1'b0, 1'b0);
    stat_is(1'b1, 1'b1, 1'b0, 3'd2, "R8");
    look(3'd0, 20'h00102, 1'b0, 20'h0, 1'b0, 1'b0, "R8");
    look(3'd0, 20'h00101, 1'b1, 20'h50001, 1'b1, 1'b0, "R9");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule